// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It captures request lines into a pending register. Each line captures either on a rising level or while the line is held high, chosen per line by a trigger-select register. The block removes masked requests and compares the best remaining request against the best line now in service. The ranking rotates: a priority base names the line that currently holds the top rank, and the other lines follow it cyclically.

When an unmasked request strictly outranks everything in service, the block raises its interrupt output and presents the winning line number. An external acknowledge/vector stage pulses `ack` to take the winner into service. A non-specific end-of-interrupt command retires the top-ranked in-service line and can rotate the ranking past it. In automatic end-of-interrupt mode, an acknowledge leaves nothing in service and can rotate the ranking. A nested-mode flag lets a line that is already in service on the cascade position interrupt again.

Top module: `rot_prio_resolver`

## Requirements
- R1: Reset clears the pending, in-service and mask registers, the stored previous input levels and the priority base, and drives `irq_out` and `win_id` to 0. The trigger-select register keeps its contents through reset. It is loaded whenever `trig_wr` is high, in reset or out of it.
- R2: A line whose trigger-select bit is 0 is edge-captured. Its pending bit sets when the line is high and its stored previous level was low. A low line clears both the pending bit and the stored level. A line held high does not set the pending bit again.
- R3: A line whose trigger-select bit is 1 is level-captured. Its pending bit is 1 in the cycle after the line is high and 0 in the cycle after it is low, whatever the acknowledge does.
- R4: A request whose bit is 1 in the mask register (loaded from `mask_data` when `mask_wr` is high) is never signalled. The mask write takes effect at the next clock edge.
- R5: Ranking rotates. Offset 0 is the best and offset 7 the worst. The line at offset p is (p + base) mod 8. `irq_out` and `win_id` are registered: they reflect the state before the previous clock edge. `win_id` is 0 whenever `irq_out` is 0.
- R6: The interrupt is raised only when the best unmasked pending offset is strictly smaller than the best in-service offset. An empty in-service set counts as offset 8.
- R7: With `nested_mode` high, in-service bit 2 (the cascade position) is left out of that comparison.
- R8: `ack` with a live winner n and `aeoi_en` low sets in-service bit n. `ack` clears pending bit n only if line n is edge-captured. `ack` with no live winner changes nothing.
- R9: `ack` with a live winner n and `aeoi_en` high sets no in-service bit. If `aeoi_rotate` is also high, the base becomes (n + 1) mod 8.
- R10: `eoi_req` clears the in-service bit with the best offset, if any bit is set. With `eoi_rotate` high, the base becomes that line + 1 mod 8. An empty in-service set makes the command a no-op.
- R11: When `ack` and `eoi_req` act in the same cycle, both take effect. The acknowledge's rotation overrides the EOI's rotation. If both touch the same in-service bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines |
| trig_wr | input | 1 | Load trigger-select register |
| trig_data | input | 8 | Trigger-select value, 1 = level, 0 = edge |
| mask_wr | input | 1 | Load mask register |
| mask_data | input | 8 | Mask value, 1 = masked |
| nested_mode | input | 1 | Exclude cascade in-service bit from comparison |
| aeoi_en | input | 1 | Automatic end-of-interrupt on acknowledge |
| aeoi_rotate | input | 1 | Rotate on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge the live winner |
| eoi_req | input | 1 | Non-specific end-of-interrupt command |
| eoi_rotate | input | 1 | Rotate past the line retired by the EOI |
| irq_out | output | 1 | Interrupt request to the processor, also winner-valid |
| win_id | output | 3 | Winning line number |

## Verification
An acknowledge and an end-of-interrupt can land in the same cycle. Both can then want to move the priority base, and in nested mode both can touch in-service bit 2. The bench drives a phase in which `ack` and `eoi_req` always pulse together, with both rotation controls active. It compares every following cycle's output against a bench model that applies the acknowledge rotation last and lets the in-service set override the clear. Because the rotated base decides later winners, a wrong precedence shows up as a wrong `win_id` within a few cycles.

// File: rtl/rpir_pkg.sv
package rpir_pkg;
  parameter int unsigned RP_N   = 8;
  localparam int unsigned RP_IDW = $clog2(RP_N);
  localparam int unsigned RP_PW  = RP_IDW + 1;
  parameter int unsigned RP_CASCADE = 2;

  // offset of the first set bit when scanning from base; RP_N means none
  function automatic logic [RP_PW-1:0] rp_scan(input logic [RP_N-1:0] v,
                                               input logic [RP_IDW-1:0] b);
    logic [RP_PW-1:0]  r;
    logic [RP_IDW-1:0] k;
    r = RP_PW'(RP_N);
    for (int p = RP_N - 1; p >= 0; p--) begin
      k = RP_IDW'(p) + b;
      if (v[k]) r = RP_PW'(p);
    end
    return r;
  endfunction

  // convert a rank offset back into a line number
  function automatic logic [RP_IDW-1:0] rp_rot(input logic [RP_PW-1:0] off,
                                               input logic [RP_IDW-1:0] b);
    logic [RP_IDW-1:0] s;
    s = off[RP_IDW-1:0] + b;
    return s;
  endfunction
endpackage

// File: rtl/rpir_scan.sv
module rpir_scan
  import rpir_pkg::*;
(
  input  logic [RP_N-1:0]   vec,
  input  logic [RP_IDW-1:0] base,
  output logic [RP_PW-1:0]  off
);
  always_comb off = rp_scan(vec, base);
endmodule

// File: rtl/rpir_req_latch.sv
module rpir_req_latch
  import rpir_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RP_N-1:0] irq_in,
  input  logic [RP_N-1:0] trig,
  input  logic [RP_N-1:0] ack_clr,
  output logic [RP_N-1:0] irr
);
  logic [RP_N-1:0] prev;

  for (genvar i = 0; i < RP_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irr[i]  <= 1'b0;
        prev[i] <= 1'b0;
      end else if (!irq_in[i]) begin
        irr[i]  <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        prev[i] <= 1'b1;
        if (trig[i])          irr[i] <= 1'b1;
        else if (ack_clr[i])  irr[i] <= 1'b0;
        else if (!prev[i])    irr[i] <= 1'b1;
      end
    end

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && irq_in[i]) |=> irr[i]);
    // R2
    low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[i] |=> !irr[i]);
  end
endmodule

// File: rtl/rpir_service.sv
module rpir_service
  import rpir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_fire,
  input  logic [RP_IDW-1:0] ack_id,
  input  logic              aeoi_en,
  input  logic              aeoi_rotate,
  input  logic              eoi_req,
  input  logic              eoi_rotate,
  input  logic [RP_PW-1:0]  eoi_off,
  output logic [RP_N-1:0]   isr,
  output logic [RP_IDW-1:0] base
);
  logic              eoi_hit;
  logic [RP_IDW-1:0] eoi_id;
  logic [RP_N-1:0]   isr_clr, isr_set;
  logic              ack_rot, eoi_rot;
  logic [RP_N-1:0]   isr_n;
  logic [RP_IDW-1:0] base_n;

  always_comb begin
    eoi_hit = eoi_req && (eoi_off != RP_PW'(RP_N));
    eoi_id  = rp_rot(eoi_off, base);
    isr_clr = eoi_hit ? (RP_N'(1) << eoi_id) : '0;
    isr_set = (ack_fire && !aeoi_en) ? (RP_N'(1) << ack_id) : '0;
    ack_rot = ack_fire && aeoi_en && aeoi_rotate;
    eoi_rot = eoi_hit && eoi_rotate;
    isr_n   = (isr & ~isr_clr) | isr_set;
    if (ack_rot)      base_n = ack_id + 1'b1;
    else if (eoi_rot) base_n = eoi_id + 1'b1;
    else              base_n = base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr  <= '0;
      base <= '0;
    end else begin
      isr  <= isr_n;
      base <= base_n;
    end
  end

  // R8
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !aeoi_en) |=> isr[$past(ack_id)]);
  // R9
  aeoi_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rot |=> (base == RP_IDW'($past(ack_id) + 1)));
  // R10
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack_fire) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RP_N-1:0]   irq_in,
  input  logic              trig_wr,
  input  logic [RP_N-1:0]   trig_data,
  input  logic              mask_wr,
  input  logic [RP_N-1:0]   mask_data,
  input  logic              nested_mode,
  input  logic              aeoi_en,
  input  logic              aeoi_rotate,
  input  logic              ack,
  input  logic              eoi_req,
  input  logic              eoi_rotate,
  output logic              irq_out,
  output logic [RP_IDW-1:0] win_id
);
  logic [RP_N-1:0]   trig, imr, irr, isr, cand, isr_cmp, ack_clr;
  logic [RP_IDW-1:0] base, live_id;
  logic [RP_PW-1:0]  cand_off, cmp_off, full_off;
  logic              live_valid, ack_fire;

  // trigger select survives reset on purpose
  always_ff @(posedge clk) begin
    if (trig_wr) trig <= trig_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       imr <= '0;
    else if (mask_wr) imr <= mask_data;
  end

  always_comb begin
    cand    = irr & ~imr;
    isr_cmp = nested_mode ? (isr & ~(RP_N'(1) << RP_CASCADE)) : isr;
  end

  rpir_scan u_cand_scan (.vec(cand),    .base(base), .off(cand_off));
  rpir_scan u_cmp_scan  (.vec(isr_cmp), .base(base), .off(cmp_off));
  rpir_scan u_full_scan (.vec(isr),     .base(base), .off(full_off));

  always_comb begin
    live_valid = cand_off < cmp_off;
    live_id    = rp_rot(cand_off, base);
    ack_fire   = ack && live_valid;
    ack_clr    = ack_fire ? (RP_N'(1) << live_id) : '0;
  end

  rpir_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig),
    .ack_clr(ack_clr), .irr(irr)
  );

  rpir_service u_svc (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .ack_id(live_id),
    .aeoi_en(aeoi_en), .aeoi_rotate(aeoi_rotate), .eoi_req(eoi_req),
    .eoi_rotate(eoi_rotate), .eoi_off(full_off), .isr(isr), .base(base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      win_id  <= '0;
    end else begin
      irq_out <= live_valid;
      win_id  <= live_valid ? live_id : '0;
    end
  end

  // R5
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> (!irq_out && win_id == '0));
  // R4
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_data == '1) |=> !ack_fire);
endmodule

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in, trig_data, mask_data;
  logic       trig_wr, mask_wr, nested_mode, aeoi_en, aeoi_rotate;
  logic       ack, eoi_req, eoi_rotate;
  logic       irq_out;
  logic [2:0] win_id;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  logic [7:0] m_irr = 0, m_prev = 0, m_isr = 0, m_imr = 0, m_trig = 0;
  logic [2:0] m_base = 0;

  always #2 clk = ~clk;

  rot_prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_wr(trig_wr),
    .trig_data(trig_data), .mask_wr(mask_wr), .mask_data(mask_data),
    .nested_mode(nested_mode), .aeoi_en(aeoi_en), .aeoi_rotate(aeoi_rotate),
    .ack(ack), .eoi_req(eoi_req), .eoi_rotate(eoi_rotate),
    .irq_out(irq_out), .win_id(win_id)
  );

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // rank offset by rotating the vector so the base line sits at bit 0
  function automatic int scan_b(input logic [7:0] v, input logic [2:0] b);
    logic [15:0] d;
    d = {v, v} >> b;
    for (int k = 0; k < 8; k++) if (d[k]) return k;
    return 8;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: {irq_out,win_id} actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    logic [7:0] cand, ie, nirr, nprev, nisr, nimr, clr, set, tw_data;
    logic [2:0] nbase, lid, hid;
    int cp, ip, ep;
    logic lv, tw;
    cand = m_irr & ~m_imr;
    cp = scan_b(cand, m_base);
    ie = nested_mode ? (m_isr & 8'hFB) : m_isr;
    ip = scan_b(ie, m_base);
    lv = cp < ip;
    lid = 3'((cp + m_base) % 8);
    nirr = m_irr; nprev = m_prev; nbase = m_base; clr = 0; set = 0;
    for (int k = 0; k < 8; k++) begin
      if (!irq_in[k]) begin nirr[k] = 0; nprev[k] = 0; end
      else begin
        if (m_trig[k] || !m_prev[k]) nirr[k] = 1;
        nprev[k] = 1;
      end
    end
    if (ack && lv) begin
      if (!aeoi_en) set[lid] = 1;
      if (!m_trig[lid]) nirr[lid] = 0;
    end
    ep = scan_b(m_isr, m_base);
    if (eoi_req && ep < 8) begin
      hid = 3'((ep + m_base) % 8);
      clr[hid] = 1;
      if (eoi_rotate) nbase = hid + 3'd1;
    end
    if (ack && lv && aeoi_en && aeoi_rotate) nbase = lid + 3'd1;
    nisr = (m_isr & ~clr) | set;
    nimr = mask_wr ? mask_data : m_imr;
    if (!rst_n) begin
      nirr = 0; nprev = 0; nisr = 0; nimr = 0; nbase = 0; lv = 0;
    end
    tw = trig_wr; tw_data = trig_data;
    @(posedge clk); #1;
    m_irr = nirr; m_prev = nprev; m_isr = nisr; m_imr = nimr; m_base = nbase;
    if (tw) m_trig = tw_data;
    check(tag, {irq_out, win_id}, {lv, lv ? lid : 3'd0});
  endtask

  task automatic run_phase(input string tag, input int n, input bit wr_t,
                           input logic [7:0] tv, input int ack_pct, input int eoi_pct,
                           input int mask_pct, input bit nest, input bit aeoi,
                           input bit arot, input int erot_pct, input bit both);
    nested_mode = nest; aeoi_en = aeoi; aeoi_rotate = arot;
    if (wr_t) begin
      trig_wr = 1; trig_data = tv; tick(tag); trig_wr = 0;
    end
    for (int c = 0; c < n; c++) begin
      irq_in    ^= 8'(rnd()) & 8'(rnd());
      mask_wr    = (rnd() % 100) < mask_pct;
      mask_data  = 8'(rnd()) & 8'(rnd());
      ack        = (rnd() % 100) < ack_pct;
      eoi_req    = both ? ack : ((rnd() % 100) < eoi_pct);
      eoi_rotate = (rnd() % 100) < erot_pct;
      tick(tag);
    end
    ack = 0; eoi_req = 0; mask_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_in = 0; trig_wr = 1; trig_data = 8'hF0; mask_wr = 0; mask_data = 0;
    nested_mode = 0; aeoi_en = 0; aeoi_rotate = 0; ack = 0; eoi_req = 0; eoi_rotate = 0;
    #1;
    repeat (3) tick("R1");
    trig_wr = 0; rst_n = 1;
    tick("R1");
    check("R1 reset state", {irq_out, win_id}, 4'h0);
    // lines 3 and 5 (edge and level) from base 0: line 3 wins
    irq_in = 8'h28; tick("R5"); tick("R5");
    check("R5 directed", {irq_out, win_id}, {1'b1, 3'd3});
    mask_wr = 1; mask_data = 8'h08; tick("R4"); mask_wr = 0; tick("R4");
    check("R4 directed", {irq_out, win_id}, {1'b1, 3'd5});
    mask_wr = 1; mask_data = 8'h00; irq_in = 0; tick("R4"); mask_wr = 0; tick("R4");

    run_phase("R2", 2000, 1, 8'h00, 30, 20, 0, 0, 0, 0, 0, 0);
    run_phase("R3", 2000, 1, 8'hFF, 30, 20, 0, 0, 0, 0, 0, 0);
    run_phase("R4", 2000, 1, 8'h5A, 25, 20, 30, 0, 0, 0, 0, 0);
    run_phase("R6/R8", 3000, 1, 8'h0F, 40, 8, 5, 0, 0, 0, 0, 0);
    run_phase("R7", 3000, 0, 8'h00, 40, 10, 5, 1, 0, 0, 30, 0);
    run_phase("R9", 3000, 0, 8'h00, 40, 5, 5, 0, 1, 1, 0, 0);
    run_phase("R10", 3000, 0, 8'h00, 30, 35, 5, 0, 0, 0, 60, 0);
    run_phase("R11", 3000, 1, 8'h33, 50, 0, 5, 1, 0, 1, 50, 1);
    run_phase("R11", 3000, 0, 8'h00, 50, 0, 5, 1, 1, 1, 50, 1);
    // reset mid-run without rewriting trigger select: modes must survive
    rst_n = 0; repeat (2) tick("R1"); rst_n = 1;
    run_phase("R1", 1500, 0, 8'h00, 30, 20, 5, 0, 0, 0, 30, 0);
    for (int b = 0; b < 8; b++)
      run_phase("R5", 400, 1, 8'(b * 37), 35, 25, 10, b[0], b[1], b[2], 50, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule